// File: doc/BRIEF.md
# SPI Serial EEPROM Page-Write Controller

This block is the slave-side control path of a byte-addressed nonvolatile memory reached over SPI mode 0. It oversamples chip select, serial clock and serial data on the system clock and assembles bytes from the rising edges of the serial clock. It then decodes a frame made of a one-byte command, a two-byte address and a run of data bytes, which go into a 64-byte page latch.

When chip select returns high, the block decides whether the write may proceed. It then runs a timed busy cycle against a behavioural storage array. The busy cycle has two halves. The first half clears the addressed cells, so an erased cell reads zero. The second half sets the programmed bits. A write-enable latch and two protection inputs gate the write. The array has a side read port, so its contents can be observed without a read command.

Top module: `spi_eeprom_writer`

## Requirements
- R1: Bits are sampled on rising serial-clock edges while chip select is low, most significant bit first. A write frame is command 0x02, then address bits 15..8, then address bits 7..0, then one or more data bytes. When accepted, the data bytes land at the address and at the locations after it.
- R2: Address bits at and above ADDR_BITS (default 10, so bits 15..10) are ignored. Addresses that differ only in those bits reach the same cell.
- R3: Command 0x06, ended at a byte boundary while not busy, sets the write-enable flag `wel`. A write frame sent while `wel` is 0 leaves the array unchanged and never raises `busy`.
- R4: A command byte received while `busy` is high is discarded. This applies to a write frame, which changes no cell, and to a write-enable frame, which leaves `wel` at 0 once the running cycle has ended.
- R5: A write frame whose chip select rises with a partial byte shifted in (bit count not a multiple of 8) is cancelled completely, and `busy` stays low.
- R6: Protection input `bp` makes whole pages read-only. With ADDR_BITS=10, 00 locks nothing, 01 locks addresses whose bits 9:8 are 11, 10 locks addresses with bit 9 set, and 11 locks every address. A write to a locked page changes nothing.
- R7: An accepted write raises `busy` on the clock edge at which chip select is first seen high and holds it for exactly WRITE_CYCLES cycles (default 400). `erasing` is high during the first half. During that half, the addressed bytes read 0 and the other bytes keep their values. After the cycle, the addressed bytes hold the new data.
- R8: Data bytes that run past the end of a 64-byte page wrap to the start of the same page. When a location is written twice in one frame, the later byte is kept.
- R9: `wel` drops to 0 when an accepted write cycle ends. A rejected write leaves `wel` as it was.
- R10: After reset, `busy`, `erasing` and `wel` are 0 and every array byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | SPI serial data into the block |
| bp | input | 2 | Block-protect setting |
| rd_addr | input | ADDR_BITS | Side read port address into the array |
| rd_data | output | 8 | Array byte at `rd_addr` (combinational) |
| busy | output | 1 | Write cycle in progress |
| erasing | output | 1 | Busy cycle is in its erase half |
| wel | output | 1 | Write-enable flag |

## Verification
The case hardest to reach from the ports is a frame that arrives while a write cycle is already running. The cycle is made long enough that a complete write-enable frame and a complete write frame both fit inside one busy window. The bench checks that `busy` is still high after both frames. It then waits for the cycle to finish and confirms that `wel` is clear and that the second target address is untouched. The erase half is caught in the same way. Reads are queued within a few cycles of chip select rising on an overwrite, and they must see zero at the addressed byte while its neighbours keep their values.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam int PAGE_BYTES = 64;
    localparam int OFS_BITS   = 6;

    typedef enum logic [2:0] {
        FR_OPCODE,
        FR_ADDR_HI,
        FR_ADDR_LO,
        FR_DATA,
        FR_SKIP
    } frame_state_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRITE
    } cmd_e;

    typedef struct packed {
        logic [7:0] value;
        logic       strobe;
    } rx_byte_t;

    // top2 = two most significant bits of the page index
    function automatic logic page_locked(input logic [1:0] bp, input logic [1:0] top2);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return top2 == 2'b11;
            2'b10:   return top2[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_ee_rx.sv
module spi_ee_rx
    import spi_ee_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     mosi,
    output rx_byte_t rx,
    output logic     at_boundary,
    output logic     cs_rise
);

    logic       sck_q;
    logic       cs_q;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic       sck_rise;

    assign sck_rise    = sck & ~sck_q & ~cs_n;
    assign cs_rise     = cs_n & ~cs_q;
    assign at_boundary = (bit_cnt == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            cs_q    <= 1'b1;
            bit_cnt <= 3'd0;
            shreg   <= '0;
            rx      <= '0;
        end else begin
            sck_q     <= sck;
            cs_q      <= cs_n;
            rx.strobe <= 1'b0;
            if (cs_n) begin
                bit_cnt <= 3'd0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], mosi};
                bit_cnt <= 3'(bit_cnt + 3'd1);
                if (bit_cnt == 3'd7) begin
                    rx.value  <= {shreg, mosi};
                    rx.strobe <= 1'b1;
                end
            end
        end
    end

    // R1: a completed byte always leaves the bit counter on a boundary
    p_byte_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        rx.strobe |-> at_boundary);

endmodule

// File: rtl/spi_ee_frame.sv
module spi_ee_frame
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS = 10
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cs_n,
    input  rx_byte_t                      rx,
    input  logic                          at_boundary,
    input  logic                          cs_rise,
    input  logic [1:0]                    bp,
    input  logic                          busy,
    input  logic                          done,
    output logic                          start,
    output logic                          wel,
    output logic [ADDR_BITS-OFS_BITS-1:0] page,
    output logic [PAGE_BYTES*8-1:0]       pbuf,
    output logic [PAGE_BYTES-1:0]         mask
);

    localparam int PAGE_BITS = ADDR_BITS - OFS_BITS;
    localparam int HI_BITS   = ADDR_BITS - 8;

    frame_state_e          st;
    cmd_e                  cmd;
    logic [HI_BITS-1:0]    addr_hi;
    logic [OFS_BITS-1:0]   ofs;
    logic                  locked;
    logic                  wren_ok;

    assign locked  = page_locked(bp, page[PAGE_BITS-1:PAGE_BITS-2]);
    assign wren_ok = cs_rise && at_boundary && (cmd == CMD_WREN) && !busy;
    assign start   = cs_rise && at_boundary && (cmd == CMD_WRITE) && (st == FR_DATA)
                     && (|mask) && wel && !busy && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FR_OPCODE;
            cmd     <= CMD_NONE;
            wel     <= 1'b0;
            addr_hi <= '0;
            page    <= '0;
            ofs     <= '0;
            pbuf    <= '0;
            mask    <= '0;
        end else begin
            if (done)
                wel <= 1'b0;
            else if (wren_ok)
                wel <= 1'b1;

            if (cs_n) begin
                st  <= FR_OPCODE;
                cmd <= CMD_NONE;
            end else if (rx.strobe) begin
                case (st)
                    FR_OPCODE: begin
                        if (busy) begin
                            st <= FR_SKIP;
                        end else if (rx.value == OP_WREN) begin
                            cmd <= CMD_WREN;
                            st  <= FR_SKIP;
                        end else if (rx.value == OP_WRITE) begin
                            cmd <= CMD_WRITE;
                            st  <= FR_ADDR_HI;
                        end else begin
                            st <= FR_SKIP;
                        end
                    end
                    FR_ADDR_HI: begin
                        addr_hi <= rx.value[HI_BITS-1:0];
                        st      <= FR_ADDR_LO;
                    end
                    FR_ADDR_LO: begin
                        page <= {addr_hi, rx.value[7:OFS_BITS]};
                        ofs  <= rx.value[OFS_BITS-1:0];
                        mask <= '0;
                        st   <= FR_DATA;
                    end
                    FR_DATA: begin
                        pbuf[ofs*8 +: 8] <= rx.value;
                        mask[ofs]        <= 1'b1;
                        ofs              <= OFS_BITS'(ofs + 1'b1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: the latch stays set for the whole write cycle and clears at its end
    p_wel_held_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> wel);
    p_wel_cleared_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !wel);
    // R5: every deselect discards the decoded command
    p_cmd_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        cs_rise |=> (cmd == CMD_NONE));

endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS    = 10,
    parameter int WRITE_CYCLES = 400
)(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_BITS-OFS_BITS-1:0] page,
    input  logic [PAGE_BYTES*8-1:0]       pbuf,
    input  logic [PAGE_BYTES-1:0]         mask,
    input  logic [ADDR_BITS-1:0]          rd_addr,
    output logic [7:0]                    rd_data,
    output logic                          busy,
    output logic                          erasing,
    output logic                          done
);

    localparam int DEPTH = 1 << ADDR_BITS;
    localparam int HALF  = WRITE_CYCLES / 2;
    localparam int CW    = $clog2(WRITE_CYCLES);

    logic [7:0]                    mem [DEPTH];
    logic [CW-1:0]                 cnt;
    logic [ADDR_BITS-OFS_BITS-1:0] page_q;

    assign erasing = busy && (cnt < CW'(HALF));
    assign done    = busy && (cnt == CW'(WRITE_CYCLES - 1));
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            cnt    <= '0;
            page_q <= '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= 8'h00;
        end else begin
            if (start) begin
                busy   <= 1'b1;
                cnt    <= '0;
                page_q <= page;
            end else if (busy) begin
                if (done)
                    busy <= 1'b0;
                else
                    cnt <= CW'(cnt + 1'b1);
            end

            if (busy && cnt == '0) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (mask[i])
                        mem[{page_q, OFS_BITS'(i)}] <= 8'h00;
            end
            if (busy && cnt == CW'(HALF)) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (mask[i])
                        mem[{page_q, OFS_BITS'(i)}] <= mem[{page_q, OFS_BITS'(i)}] | pbuf[i*8 +: 8];
            end
        end
    end

    // R7: a cycle opens in the erase half and never returns to it
    p_erase_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> erasing);
    p_phase_order_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !erasing) |=> !erasing);
    // R4: no new write is launched on top of a running one
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/spi_eeprom_writer.sv
module spi_eeprom_writer
    import spi_ee_pkg::*;
#(
    parameter int ADDR_BITS    = 10,
    parameter int WRITE_CYCLES = 400
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 mosi,
    input  logic [1:0]           bp,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [7:0]           rd_data,
    output logic                 busy,
    output logic                 erasing,
    output logic                 wel
);

    localparam int PAGE_BITS = ADDR_BITS - OFS_BITS;

    rx_byte_t               rx;
    logic                   at_boundary;
    logic                   cs_rise;
    logic                   start;
    logic                   done;
    logic [PAGE_BITS-1:0]   page;
    logic [PAGE_BYTES*8-1:0] pbuf;
    logic [PAGE_BYTES-1:0]  mask;

    spi_ee_rx u_rx (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sck         (sck),
        .mosi        (mosi),
        .rx          (rx),
        .at_boundary (at_boundary),
        .cs_rise     (cs_rise)
    );

    spi_ee_frame #(.ADDR_BITS(ADDR_BITS)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .rx          (rx),
        .at_boundary (at_boundary),
        .cs_rise     (cs_rise),
        .bp          (bp),
        .busy        (busy),
        .done        (done),
        .start       (start),
        .wel         (wel),
        .page        (page),
        .pbuf        (pbuf),
        .mask        (mask)
    );

    spi_ee_store #(.ADDR_BITS(ADDR_BITS), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .page    (page),
        .pbuf    (pbuf),
        .mask    (mask),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .busy    (busy),
        .erasing (erasing),
        .done    (done)
    );

endmodule

// File: tb/test_spi_eeprom_writer.sv
module test_spi_eeprom_writer;

    localparam int AB = 10;
    localparam int WC = 400;
    localparam int DEPTH = 1 << AB;

    typedef struct {
        logic [AB-1:0] addr;
        logic [7:0]    exp;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          mosi = 1'b0;
    logic [1:0]    bp = 2'b00;
    logic [AB-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy;
    logic          erasing;
    logic          wel;

    int    n_tests = 0;
    int    n_fail  = 0;
    logic [7:0] model [DEPTH];
    logic [7:0] tx_q [$];
    logic [7:0] dq [$];
    item_t exp_q [$];
    bit    mon_busy = 1'b0;

    always #10 clk = ~clk;

    spi_eeprom_writer #(.ADDR_BITS(AB), .WRITE_CYCLES(WC)) i_spi_eeprom_writer (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi), .bp(bp),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .erasing(erasing), .wel(wel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected array bytes and compares the read port
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            if (exp_q.size() != 0) begin
                mon_busy = 1'b1;
                it = exp_q.pop_front();
                @(negedge clk) rd_addr = it.addr;
                @(negedge clk) chk(it.tag, int'(rd_data), int'(it.exp));
                mon_busy = 1'b0;
            end
        end
    end

    task automatic push(input int a, input int e, input string tag);
        item_t it;
        it.addr = AB'(a);
        it.exp  = 8'(e);
        it.tag  = tag;
        exp_q.push_back(it);
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || mon_busy) @(posedge clk);
    endtask

    task automatic send_bit(input logic v);
        @(negedge clk) mosi = v;
        @(negedge clk) sck = 1'b1;
        @(negedge clk) sck = 1'b0;
    endtask

    // sends tx_q plus extra 1-bits; returns at the negedge just after cs_n rose
    task automatic xfer(input int extra);
        @(negedge clk) cs_n = 1'b0;
        foreach (tx_q[k])
            for (int b = 7; b >= 0; b--) send_bit(tx_q[k][b]);
        for (int e = 0; e < extra; e++) send_bit(1'b1);
        @(negedge clk);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wren();
        tx_q = '{8'h06};
        xfer(0);
        repeat (2) @(negedge clk);
    endtask

    task automatic load_write(input logic [15:0] a);
        tx_q = '{8'h02, a[15:8], a[7:0]};
        foreach (dq[k]) tx_q.push_back(dq[k]);
    endtask

    task automatic model_write(input logic [15:0] a);
        int base = int'(a) & (DEPTH - 1);
        int pg = base & ~63;
        foreach (dq[k]) model[pg | ((base + k) & 63)] = dq[k];
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] a, input bit accept, input int extra, input string tag);
        int cnt = 0;
        load_write(a);
        xfer(extra);
        if (accept) begin
            while (busy) begin
                cnt++;
                @(negedge clk);
            end
            chk({tag, " busy length"}, cnt, WC);
            model_write(a);
            @(negedge clk);
            chk({tag, " wel cleared R9"}, int'(wel), 0);
        end else begin
            repeat (3) @(negedge clk);
            chk({tag, " no busy on reject"}, int'(busy), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 wel", int'(wel), 0);
        chk("R10 erasing", int'(erasing), 0);
        for (int i = 0; i < DEPTH; i++) push(i, 0, "R10 array");
        drain();

        // R3 write without write-enable
        dq = '{8'hAA};
        do_write(16'h0010, 1'b0, 0, "R3 no wel");
        push(16'h0010, model[16'h0010], "R3 array untouched");
        drain();

        // R3 / R1 / R7 accepted write
        wren();
        chk("R3 wel set", int'(wel), 1);
        dq = '{8'h11, 8'h22, 8'h33};
        do_write(16'h0040, 1'b1, 0, "R7");
        for (int i = 16'h3E; i <= 16'h44; i++) push(i, model[i], "R1 data");
        drain();

        // R7 erase-then-program observed during the cycle
        wren();
        dq = '{8'h5A};
        load_write(16'h0041);
        xfer(0);
        repeat (2) @(negedge clk);
        chk("R7 erasing", int'(erasing), 1);
        push(16'h0041, 8'h00, "R7 erased byte");
        push(16'h0040, 8'h11, "R7 neighbour kept");
        push(16'h0042, 8'h33, "R7 neighbour kept");
        drain();
        chk("R7 still busy", int'(busy), 1);
        wait_idle();
        model_write(16'h0041);
        push(16'h0041, 8'h5A, "R7 programmed");
        drain();

        // R8 wrap within a page
        wren();
        dq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
        do_write(16'h00BE, 1'b1, 0, "R8 wrap");
        push(16'h00BE, 8'h01, "R8 tail");
        push(16'h00BF, 8'h02, "R8 tail");
        push(16'h0080, 8'h03, "R8 wrapped");
        push(16'h0082, 8'h05, "R8 wrapped");
        push(16'h00C0, 8'h00, "R8 next page untouched");
        drain();

        // R8 last value wins
        wren();
        dq.delete();
        for (int k = 0; k < 66; k++) dq.push_back(8'(k + 1));
        do_write(16'h00C0, 1'b1, 0, "R8 overwrite");
        push(16'h00C0, 8'd65, "R8 last wins");
        push(16'h00C1, 8'd66, "R8 last wins");
        push(16'h00C2, 8'd3, "R8 single");
        drain();

        // R2 aliasing of high address bits
        wren();
        dq = '{8'h77};
        do_write(16'hFC05, 1'b1, 0, "R2 alias");
        push(16'h0005, 8'h77, "R2 aliased cell");
        drain();

        // R4 frames during busy
        wren();
        dq = '{8'h42};
        load_write(16'h0100);
        xfer(0);
        tx_q = '{8'h06};
        xfer(0);
        dq = '{8'h99};
        load_write(16'h0120);
        xfer(0);
        chk("R4 busy spans frames", int'(busy), 1);
        wait_idle();
        dq = '{8'h42};
        model_write(16'h0100);
        chk("R4 wren ignored while busy", int'(wel), 0);
        push(16'h0120, 8'h00, "R4 write ignored");
        push(16'h0100, 8'h42, "R4 first write");
        drain();

        // R5 partial byte cancels write
        wren();
        dq = '{8'h44};
        do_write(16'h0200, 1'b0, 3, "R5 partial");
        chk("R9 wel kept on reject", int'(wel), 1);
        push(16'h0200, 8'h00, "R5 array untouched");
        drain();

        // R6 protection
        bp = 2'b01;
        dq = '{8'h55};
        do_write(16'h0300, 1'b0, 0, "R6 upper quarter");
        dq = '{8'h66};
        do_write(16'h02C0, 1'b1, 0, "R6 below quarter");
        wren();
        bp = 2'b10;
        dq = '{8'h12};
        do_write(16'h0200, 1'b0, 0, "R6 upper half");
        bp = 2'b11;
        do_write(16'h0010, 1'b0, 0, "R6 all");
        bp = 2'b00;
        push(16'h0300, 8'h00, "R6 locked quarter");
        push(16'h02C0, 8'h66, "R6 open page");
        push(16'h0200, 8'h00, "R6 locked half");
        push(16'h0010, 8'h00, "R6 locked all");
        drain();

        // R1 final full comparison
        for (int i = 0; i < DEPTH; i++) push(i, model[i], "R1 final scan");
        drain();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule